// File: doc/BRIEF.md
# Class-Priority Maximum-Weight Accept Arbiter

This block is the accept stage for one input port of a cell switch whose matching runs as a series of iterations inside each cell slot. In an iteration, every output may hand this input a grant. A grant carries one traffic-class code and one waiting-time weight, and a weight of zero means no grant. The arbiter accepts exactly one grant. The lowest class code with any grant wins. Within that class, the largest weight wins. Equal weights are settled by a scan that starts at a position which rotates from slot to slot.

The accepted output is returned as a one-hot vector together with the class code, so that the output can credit its per-class counter. Once an input has accepted, it reports itself as matched. The request logic uses that flag to mask the input for the rest of the slot. A slot-start pulse clears the matched state and advances the rotation.

Top module: `accept_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `matched`, `acc_valid`, `acc_onehot` and `acc_cls` all become zero.
- R2: An acceptance is made only in a cycle where `iter_valid` is 1, `slot_start` is 0, `matched` is 0 and at least one grant weight is non-zero. The result appears on the registered outputs at the next edge, and `acc_valid` is high for that one cycle only.
- R3: Grant j is taken from `grant_cls[j*CLS_W +: CLS_W]` and `grant_wt[j*WT_W +: WT_W]`. A grant whose weight is zero is ignored. Among the grants with non-zero weight, the smallest class code wins, whatever the weights of the other classes.
- R4: Within the winning class, the grant with the largest weight is accepted.
- R5: Among equal weights in the winning class, outputs are scanned upward from start position s = (PORT_ID + t) mod N_OUT, wrapping past N_OUT-1 to 0. The first one met is accepted.
- R6: The slot count t is 0 after reset and steps by one, modulo N_OUT, on every cycle where `slot_start` is 1.
- R7: After an acceptance, `matched` stays 1 and no further acceptance occurs until a `slot_start` cycle.
- R8: A `slot_start` cycle clears `matched` and produces no acceptance, even if `iter_valid` and grants are present in the same cycle.
- R9: When `acc_valid` is 1, bit j of `acc_onehot` marks output j and `acc_cls` holds that grant's class code. When `acc_valid` is 0, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Marks the first cycle of a cell slot |
| iter_valid | input | 1 | Grants on this cycle form one iteration |
| grant_cls | input | N_OUT*CLS_W | Class code per output |
| grant_wt | input | N_OUT*WT_W | Weight per output, zero means no grant |
| matched | output | 1 | Input already matched in this slot |
| acc_valid | output | 1 | One-cycle pulse for an acceptance |
| acc_onehot | output | N_OUT | Accepted output |
| acc_cls | output | CLS_W | Class of the accepted grant |

## Verification
Directed patterns separate the ordering rules. A light grant in a better class is set against a heavy grant in a worse class, which shows that class outranks weight. Unequal weights in a single class show the maximum search. Four identical grants, repeated over a full rotation of slots, show the start position moving with the slot count. A second iteration in the same slot, and a slot start coinciding with grants, tell the masking and clearing rules apart. A long pseudo-random sweep with weights drawn from a narrow range produces frequent ties across mixed classes. Each result is compared with a bench model that scans classes, weights and positions directly.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // distance going upward from s to j around a ring of n positions
  function automatic int ring_dist(input int j, input int s, input int n);
    return (j + n - s) % n;
  endfunction

  function automatic int ring_add(input int a, input int b, input int n);
    return (a + b) % n;
  endfunction
endpackage

// File: rtl/arb_key_gen.sv
module arb_key_gen #(
  parameter int N_OUT = 4,
  parameter int N_CLS = 6,
  parameter int WT_W  = 4,
  localparam int CLS_W = $clog2(N_CLS),
  localparam int IDX_W = $clog2(N_OUT),
  localparam int KEY_W = 1 + CLS_W + WT_W + IDX_W
) (
  input  logic [N_OUT*CLS_W-1:0] grant_cls,
  input  logic [N_OUT*WT_W-1:0]  grant_wt,
  input  logic [IDX_W-1:0]       start,
  output logic [N_OUT*KEY_W-1:0] keys
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_key
    logic [CLS_W-1:0] cls;
    logic [WT_W-1:0]  wt;
    logic             vld;
    logic [CLS_W-1:0] inv_cls;
    logic [IDX_W-1:0] rank;
    assign cls     = grant_cls[j*CLS_W +: CLS_W];
    assign wt      = grant_wt[j*WT_W +: WT_W];
    assign vld     = |wt;
    assign inv_cls = CLS_W'(N_CLS - 1) - cls;
    assign rank    = IDX_W'(N_OUT - 1 - arb_pkg::ring_dist(j, int'(start), N_OUT));
    assign keys[j*KEY_W +: KEY_W] = vld ? {1'b1, inv_cls, wt, rank} : '0;
  end
endmodule

// File: rtl/arb_max_tree.sv
module arb_max_tree #(
  parameter int N_LEAF = 4,
  parameter int KEY_W  = 8,
  localparam int IDX_W = $clog2(N_LEAF),
  localparam int P     = 1 << IDX_W
) (
  input  logic [N_LEAF*KEY_W-1:0] keys,
  output logic [KEY_W-1:0]        best_key,
  output logic [IDX_W-1:0]        best_idx
);
  for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
    localparam int W = P >> l;
    logic [KEY_W-1:0] k [W];
    logic [IDX_W-1:0] x [W];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_in
        if (j < N_LEAF) begin : g_real
          assign k[j] = keys[j*KEY_W +: KEY_W];
        end else begin : g_pad
          assign k[j] = '0;
        end
        assign x[j] = IDX_W'(j);
      end
    end else begin : g_node
      for (genvar n = 0; n < W; n++) begin : g_cmp
        logic left_wins;
        assign left_wins = g_lvl[l-1].k[2*n] >= g_lvl[l-1].k[2*n+1];
        assign k[n] = left_wins ? g_lvl[l-1].k[2*n] : g_lvl[l-1].k[2*n+1];
        assign x[n] = left_wins ? g_lvl[l-1].x[2*n] : g_lvl[l-1].x[2*n+1];
      end
    end
  end
  assign best_key = g_lvl[IDX_W].k[0];
  assign best_idx = g_lvl[IDX_W].x[0];
endmodule

// File: rtl/accept_arbiter.sv
module accept_arbiter #(
  parameter int N_OUT   = 4,
  parameter int N_CLS   = 6,
  parameter int WT_W    = 4,
  parameter int PORT_ID = 2,
  localparam int CLS_W  = $clog2(N_CLS),
  localparam int IDX_W  = $clog2(N_OUT),
  localparam int KEY_W  = 1 + CLS_W + WT_W + IDX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   slot_start,
  input  logic                   iter_valid,
  input  logic [N_OUT*CLS_W-1:0] grant_cls,
  input  logic [N_OUT*WT_W-1:0]  grant_wt,
  output logic                   matched,
  output logic                   acc_valid,
  output logic [N_OUT-1:0]       acc_onehot,
  output logic [CLS_W-1:0]       acc_cls
);
  logic [IDX_W-1:0]       slot_t;
  logic [IDX_W-1:0]       start;
  logic [N_OUT*KEY_W-1:0] keys;
  logic [KEY_W-1:0]       best_key;
  logic [IDX_W-1:0]       best_idx;
  logic                   take;

  assign start = IDX_W'(arb_pkg::ring_add(PORT_ID % N_OUT, int'(slot_t), N_OUT));

  arb_key_gen #(.N_OUT(N_OUT), .N_CLS(N_CLS), .WT_W(WT_W)) u_keys (
    .grant_cls(grant_cls), .grant_wt(grant_wt), .start(start), .keys(keys)
  );

  arb_max_tree #(.N_LEAF(N_OUT), .KEY_W(KEY_W)) u_tree (
    .keys(keys), .best_key(best_key), .best_idx(best_idx)
  );

  assign take = iter_valid && !slot_start && !matched && best_key[KEY_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_t     <= '0;
      matched    <= 1'b0;
      acc_valid  <= 1'b0;
      acc_onehot <= '0;
      acc_cls    <= '0;
    end else begin
      if (slot_start) begin
        slot_t  <= (slot_t == IDX_W'(N_OUT - 1)) ? '0 : slot_t + 1'b1;
        matched <= 1'b0;
      end else if (take) begin
        matched <= 1'b1;
      end
      acc_valid  <= take;
      acc_onehot <= take ? (N_OUT'(1) << best_idx) : '0;
      acc_cls    <= take ? CLS_W'(N_CLS - 1) - best_key[KEY_W-2 -: CLS_W] : '0;
    end
  end
endmodule

// File: rtl/accept_arbiter_chk.sv
module accept_arbiter_chk #(
  parameter int N_OUT = 4,
  parameter int N_CLS = 6,
  parameter int WT_W  = 4,
  localparam int CLS_W = $clog2(N_CLS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   slot_start,
  input logic                   iter_valid,
  input logic [N_OUT*WT_W-1:0]  grant_wt,
  input logic                   matched,
  input logic                   acc_valid,
  input logic [N_OUT-1:0]       acc_onehot,
  input logic [CLS_W-1:0]       acc_cls
);
  p_accept_cause_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $past(iter_valid && !slot_start && !matched && (|grant_wt)));
  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot(acc_onehot));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (acc_onehot == '0 && acc_cls == '0));
  p_cls_range_r3: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (int'(acc_cls) < N_CLS));
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (matched && !slot_start) |=> (matched && !acc_valid));
  p_slot_clear_r8: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> (!matched && !acc_valid));
  p_match_follows_r7: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> matched);
endmodule

bind accept_arbiter accept_arbiter_chk #(.N_OUT(N_OUT), .N_CLS(N_CLS), .WT_W(WT_W)) u_chk (
  .clk(clk), .rst(rst), .slot_start(slot_start), .iter_valid(iter_valid),
  .grant_wt(grant_wt), .matched(matched), .acc_valid(acc_valid),
  .acc_onehot(acc_onehot), .acc_cls(acc_cls)
);

// File: tb/test_accept_arbiter.sv
module test_accept_arbiter;
  localparam int N = 4, K = 6, WW = 4, PID = 2;
  localparam int CW = $clog2(K);

  logic clk = 1'b0, rst = 1'b1, slot_start = 1'b0, iter_valid = 1'b0;
  logic [N*CW-1:0] grant_cls = '0;
  logic [N*WW-1:0] grant_wt = '0;
  logic matched, acc_valid;
  logic [N-1:0] acc_onehot;
  logic [CW-1:0] acc_cls;

  int checks = 0, failures = 0, bt = 0;
  bit bmatched = 0, done = 0;
  int gc [N];
  int gw [N];
  int unsigned rs = 32'h1234_5678;

  accept_arbiter #(.N_OUT(N), .N_CLS(K), .WT_W(WW), .PORT_ID(PID)) i_accept_arbiter (
    .clk(clk), .rst(rst), .slot_start(slot_start), .iter_valid(iter_valid),
    .grant_cls(grant_cls), .grant_wt(grant_wt), .matched(matched),
    .acc_valid(acc_valid), .acc_onehot(acc_onehot), .acc_cls(acc_cls)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  // bench model: class scan, then maximum weight, then first from start
  function automatic int model(input int start, output int cls);
    cls = 0;
    for (int c = 0; c < K; c++) begin
      int best = -1, mw = 0;
      for (int d = 0; d < N; d++) begin
        int j = (start + d) % N;
        if (gw[j] > 0 && gc[j] == c && gw[j] > mw) begin mw = gw[j]; best = j; end
      end
      if (best >= 0) begin cls = c; return best; end
    end
    return -1;
  endfunction

  task automatic drive_grants();
    for (int j = 0; j < N; j++) begin
      grant_cls[j*CW +: CW] = CW'(gc[j]);
      grant_wt[j*WW +: WW]  = WW'(gw[j]);
    end
  endtask

  task automatic iter(input bit iv, input bit sl, input string req);
    int ei, ec;
    bit exp_acc;
    @(negedge clk);
    drive_grants();
    iter_valid = iv; slot_start = sl;
    ei = model((PID + bt) % N, ec);
    @(negedge clk);
    iter_valid = 0; slot_start = 0;
    exp_acc = iv && !sl && !bmatched && ei >= 0;
    if (sl) begin bt = (bt + 1) % N; bmatched = 0; end
    else if (exp_acc) bmatched = 1;
    check({req, " acc_valid"}, int'(acc_valid), int'(exp_acc));
    check({req, " onehot"}, int'(acc_onehot), exp_acc ? (1 << ei) : 0);
    check({req, " cls"}, int'(acc_cls), exp_acc ? ec : 0);
    check({req, " matched"}, int'(matched), int'(bmatched));
  endtask

  task automatic new_slot();
    for (int j = 0; j < N; j++) begin gc[j] = 0; gw[j] = 0; end
    iter(0, 1, "R6 R8 slot");
  endtask

  task automatic setg(input int j, input int c, input int w);
    gc[j] = c; gw[j] = w;
  endtask

  initial begin
    for (int j = 0; j < N; j++) begin gc[j] = 0; gw[j] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 matched", int'(matched), 0);
    check("R1 acc_valid", int'(acc_valid), 0);
    check("R1 onehot", int'(acc_onehot), 0);
    @(negedge clk); rst = 0;

    // R2: no grants, then grants without iter_valid
    iter(1, 0, "R2 empty");
    setg(1, 2, 5);
    iter(0, 0, "R2 idle");
    // R3: light grant in better class beats heavy grant in worse class
    new_slot();
    setg(0, 3, 15); setg(3, 1, 1); setg(2, 4, 9);
    iter(1, 0, "R3 class");
    // R7: second iteration in same slot must not accept
    setg(1, 0, 7);
    iter(1, 0, "R7 masked");
    // R8: slot start together with grants
    iter(1, 1, "R8 overlap");
    // R4: max weight within a class
    setg(0, 2, 3); setg(1, 2, 11); setg(2, 2, 6); setg(3, 5, 15);
    iter(1, 0, "R4 weight");
    // R5, R6: full ties over a full rotation of slots
    for (int s = 0; s < 2 * N; s++) begin
      new_slot();
      for (int j = 0; j < N; j++) setg(j, 1, 4);
      iter(1, 0, "R5 tie");
    end
    // R3 R4 R5 R9: pseudo-random sweep with narrow weights
    for (int n = 0; n < 1500; n++) begin
      new_slot();
      for (int j = 0; j < N; j++) begin
        int unsigned r = rnd();
        setg(j, int'(r % K), int'((r >> 8) % 4));
      end
      iter(1, 0, "R9 sweep");
      if (n % 7 == 0) iter(1, 0, "R7 sweep");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule